// File: doc/BRIEF.md
# Path Activation Monitor

This block watches the per-cycle control signals that a controller drives into a data path. It decides whether one chosen register-to-register path is ever exercised across two back-to-back clock cycles. A path counts as exercised when three things hold. The starting register loads in one cycle. The ending register loads in the next cycle. Every multiplexer on the path steers the path input in that second cycle. Plain toggling of a control line is not enough.

The monitor reports each such cycle pair as a one-cycle pulse. It keeps a sticky flag and a saturating count of the pairs it has seen. When a clear/evaluate command arrives, it latches an untestable verdict for the observation window that just ended. Two parameters handle path ends that are chip pins: `START_IS_PI` treats the start as always loading, and `END_IS_PO` treats the end as always capturing. The select code that means "path chosen" is set per multiplexer slot by the `PATH_SEL` parameter.

Top module: `path_act_mon`

## Requirements
- R1: After reset, `act_pulse`, `act_seen`, `act_count` and `untestable` are all 0.
- R2: `act_pulse` is 1 in cycle t only if `start_ld` was 1 in cycle t-1.
- R3: `act_pulse` is 1 in cycle t only if `end_ld` is 1 in cycle t.
- R4: Slot k's select is `mux_sel[k*SEL_W +: SEL_W]`, and its path code is `PATH_SEL[k*SEL_W +: SEL_W]`. In cycle t, `act_pulse` is 1 exactly when R2 and R3 hold, a pair exists (R6), and every slot with `slot_en[k]`=1 shows its path code.
- R5: A slot with `slot_en[k]`=0 has no effect on `act_pulse`, whatever its select value.
- R6: No pair is formed in the first cycle after reset, nor in the first cycle after a cycle with `clr`=1. `act_pulse` is 0 in that cycle.
- R7: `act_seen` rises in the cycle after a pulse and stays 1 until a clear.
- R8: `act_count` rises by one in the cycle after each pulse and stops at 2^CNT_W-1.
- R9: A cycle with `clr`=1 zeroes `act_seen`, `act_count` and the pair history at the next edge. At that same edge it sets `untestable` to 1 if no pulse occurred since the last reset or clear, counting the `clr` cycle itself, and to 0 otherwise. `untestable` holds until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear/evaluate command |
| start_ld | input | 1 | Load enable of the starting register |
| end_ld | input | 1 | Load enable of the ending register |
| mux_sel | input | N_MUX*SEL_W | Select lines of the path multiplexers, slot k at bits k*SEL_W |
| slot_en | input | N_MUX | Per-slot enable; 0 marks an unused slot |
| act_pulse | output | 1 | Path exercised by the pair (t-1, t) |
| act_seen | output | 1 | Sticky flag: at least one pulse since the last clear |
| act_count | output | CNT_W | Saturating pulse count |
| untestable | output | 1 | Verdict latched at the last clear |

## Verification
A pulse and a clear can fall in the same cycle. In that case the verdict must count the pulse, while the flag and the count still return to zero. The bench provokes this coincidence both on purpose and through random `clr` assertions that land on qualifying cycles. Its reference model then expects `untestable`=0 with zeroed flag and count. A second coincidence is a pulse arriving while the count is already at its ceiling. The bench drives more pulses than the count can hold and checks that the value stays pinned.

// File: rtl/pam_pkg.sv
package pam_pkg;
  // saturating increment on a 32-bit carrier; callers slice to width
  function automatic logic [31:0] sat_step(logic [31:0] cur, logic [31:0] top, logic bump);
    if (!bump || cur == top) return cur;
    return cur + 32'd1;
  endfunction

  // one multiplexer slot agrees with the path when unused or on the path code
  function automatic logic slot_agrees(logic used, logic [31:0] sel, logic [31:0] code);
    return !used || (sel == code);
  endfunction
endpackage

// File: rtl/pam_hist.sv
module pam_hist #(
  parameter bit START_IS_PI = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start_ld,
  output logic pair_valid,
  output logic pair_launch
);
  logic launch_now;

  generate
    if (START_IS_PI) begin : g_pi
      assign launch_now = 1'b1;
    end else begin : g_reg
      assign launch_now = start_ld;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pair_valid  <= 1'b0;
      pair_launch <= 1'b0;
    end else begin
      pair_valid  <= 1'b1;
      pair_launch <= launch_now;
    end
  end

  // R6: history is empty right after a clear
  a_r6_no_pair_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pair_valid);
endmodule

// File: rtl/pam_selchk.sv
module pam_selchk
  import pam_pkg::*;
#(
  parameter int N_MUX = 3,
  parameter int SEL_W = 2,
  parameter logic [N_MUX*SEL_W-1:0] PATH_SEL = '0
) (
  input  logic [N_MUX*SEL_W-1:0] mux_sel,
  input  logic [N_MUX-1:0]       slot_en,
  output logic                   path_ok
);
  logic [N_MUX-1:0] slot_hit;

  for (genvar k = 0; k < N_MUX; k++) begin : g_slot
    logic [SEL_W-1:0] sel_k;
    logic [SEL_W-1:0] code_k;
    assign sel_k  = mux_sel[k*SEL_W +: SEL_W];
    assign code_k = PATH_SEL[k*SEL_W +: SEL_W];
    assign slot_hit[k] = slot_agrees(slot_en[k], 32'(sel_k), 32'(code_k));
  end

  assign path_ok = &slot_hit;
endmodule

// File: rtl/pam_tally.sv
module pam_tally
  import pam_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             act,
  output logic             seen,
  output logic [CNT_W-1:0] count,
  output logic             untestable
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0] next_wide;
  assign next_wide = sat_step(32'(count), 32'(CNT_MAX), act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      count      <= '0;
      untestable <= 1'b0;
    end else if (clr) begin
      untestable <= !(seen || act);
      seen       <= 1'b0;
      count      <= '0;
    end else begin
      seen  <= seen | act;
      count <= next_wide[CNT_W-1:0];
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !clr) |=> seen);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !clr && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));
  a_r9_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (untestable == !($past(seen) || $past(act))) && !seen && count == '0);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(untestable));
endmodule

// File: rtl/path_act_mon.sv
module path_act_mon #(
  parameter int N_MUX = 3,
  parameter int SEL_W = 2,
  parameter int CNT_W = 8,
  parameter bit START_IS_PI = 1'b0,
  parameter bit END_IS_PO = 1'b0,
  parameter logic [N_MUX*SEL_W-1:0] PATH_SEL = {2'd2, 2'd1, 2'd3}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   start_ld,
  input  logic                   end_ld,
  input  logic [N_MUX*SEL_W-1:0] mux_sel,
  input  logic [N_MUX-1:0]       slot_en,
  output logic                   act_pulse,
  output logic                   act_seen,
  output logic [CNT_W-1:0]       act_count,
  output logic                   untestable
);
  logic pair_valid;
  logic pair_launch;
  logic capture_now;
  logic path_ok;

  pam_hist #(.START_IS_PI(START_IS_PI)) hist_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start_ld(start_ld),
    .pair_valid(pair_valid), .pair_launch(pair_launch)
  );

  pam_selchk #(.N_MUX(N_MUX), .SEL_W(SEL_W), .PATH_SEL(PATH_SEL)) selchk_i (
    .mux_sel(mux_sel), .slot_en(slot_en), .path_ok(path_ok)
  );

  generate
    if (END_IS_PO) begin : g_po
      assign capture_now = 1'b1;
    end else begin : g_reg
      assign capture_now = end_ld;
    end
  endgenerate

  assign act_pulse = pair_valid & pair_launch & capture_now & path_ok;

  pam_tally #(.CNT_W(CNT_W)) tally_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .act(act_pulse),
    .seen(act_seen), .count(act_count), .untestable(untestable)
  );

  generate
    if (!START_IS_PI) begin : g_chk_launch
      // R2: a pulse needs a load of the start one cycle earlier
      a_r2_launch_prior: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && act_pulse) |-> $past(start_ld));
    end
    if (!END_IS_PO) begin : g_chk_capture
      // R3: a pulse needs a load of the end in the same cycle
      a_r3_capture_now: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |-> end_ld);
    end
  endgenerate

  // R4: a pulse never coexists with a mis-steered enabled slot
  a_r4_steer: assert property (@(posedge clk) disable iff (!rst_n)
    !path_ok |-> !act_pulse);
  // R1/R6: the first cycle out of reset forms no pair
  a_r6_post_reset: assert property (@(posedge clk)
    !rst_n |=> !act_pulse);
endmodule

// File: tb/path_act_mon_tb_top.sv
module path_act_mon_tb_top;
  localparam int N_MUX = 3;
  localparam int SEL_W = 2;
  localparam int CNT_W = 8;
  localparam logic [N_MUX*SEL_W-1:0] CFG = {2'd2, 2'd1, 2'd3};
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, start_ld = 1'b0, end_ld = 1'b0;
  logic [N_MUX*SEL_W-1:0] mux_sel = '0;
  logic [N_MUX-1:0] slot_en = '0;
  logic act_pulse, act_seen, untestable;
  logic [CNT_W-1:0] act_count;

  int tests = 0, fails = 0;
  bit m_pv = 0, m_pl = 0, m_seen = 0, m_unt = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  path_act_mon #(.N_MUX(N_MUX), .SEL_W(SEL_W), .CNT_W(CNT_W), .PATH_SEL(CFG)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start_ld(start_ld), .end_ld(end_ld),
    .mux_sel(mux_sel), .slot_en(slot_en), .act_pulse(act_pulse),
    .act_seen(act_seen), .act_count(act_count), .untestable(untestable)
  );

  function automatic bit steer_ok(logic [N_MUX*SEL_W-1:0] s, logic [N_MUX-1:0] en);
    for (int k = 0; k < N_MUX; k++)
      if (en[k] && (((s >> (k*SEL_W)) & 3) != ((CFG >> (k*SEL_W)) & 3))) return 0;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, compare outputs, then advance the model past the edge
  task automatic step(bit s, bit e, logic [N_MUX*SEL_W-1:0] sel, logic [N_MUX-1:0] en,
                      bit c, string tag);
    bit exp_p;
    @(negedge clk);
    start_ld = s; end_ld = e; mux_sel = sel; slot_en = en; clr = c;
    #1;
    exp_p = m_pv && m_pl && e && steer_ok(sel, en);
    check(tag, act_pulse, exp_p);
    check("R7", act_seen, m_seen);
    check("R8", act_count, m_cnt);
    check("R9", untestable, m_unt);
    if (c) begin
      m_unt = !(m_seen || exp_p);
      m_seen = 0; m_cnt = 0; m_pv = 0; m_pl = 0;
    end else begin
      if (exp_p) begin m_seen = 1; if (m_cnt < CMAX) m_cnt++; end
      m_pv = 1; m_pl = s;
    end
  endtask

  localparam logic [5:0] GOOD = {2'd2, 2'd1, 2'd3};

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #1;
    check("R1", act_pulse, 0); check("R1", act_seen, 0);
    check("R1", act_count, 0); check("R1", untestable, 0);
    @(negedge clk); rst_n = 1'b1;
    // R6: first cycle after reset forms no pair even if all conditions hold
    step(1, 1, GOOD, 3'b111, 0, "R6");
    step(1, 1, GOOD, 3'b111, 0, "R4");
    step(0, 1, GOOD, 3'b111, 0, "R4");
    step(1, 1, GOOD, 3'b111, 0, "R2");   // previous start was 0
    step(1, 0, GOOD, 3'b111, 0, "R3");   // no capture
    step(1, 1, {2'd2, 2'd0, 2'd3}, 3'b111, 0, "R4");  // slot1 off path
    step(1, 1, {2'd2, 2'd0, 2'd3}, 3'b101, 0, "R5");  // slot1 unused
    step(1, 1, 6'b000000, 3'b000, 0, "R5");          // all slots unused
    // clear coinciding with a pulse: verdict counts it
    step(1, 1, GOOD, 3'b111, 1, "R9");
    step(1, 1, GOOD, 3'b111, 0, "R6");
    // window with no pulse -> untestable
    step(1, 0, GOOD, 3'b111, 0, "R3");
    step(1, 0, GOOD, 3'b111, 1, "R9");
    step(0, 0, GOOD, 3'b111, 0, "R9");
    // saturation: more pulses than the counter holds
    for (int i = 0; i < CMAX + 20; i++) step(1, 1, GOOD, 3'b111, 0, "R8");
    step(0, 0, GOOD, 3'b111, 1, "R9");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] rs;
      bit c;
      rs = ($urandom % 4 == 0) ? 6'($urandom) : GOOD;
      c = ($urandom % 40 == 0);
      step(1'($urandom), ($urandom % 4) != 0, rs, 3'($urandom) | 3'b001, c, "R4");
    end
    step(0, 0, GOOD, 3'b111, 0, "R7");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule